// File: doc/BRIEF.md
# Dual-Mode Control Port Register Slave

This block is a serial slave that loads a small bank of eight-bit configuration registers. After reset it listens on a two-wire I2C bus. One pin, `sel_i`, serves two purposes. In I2C mode its level is the least significant bit of the slave address. A falling edge on it switches the port to SPI mode, and the port then stays in SPI mode until the next reset. In SPI mode the same pin is an active-low chip select, and the I2C clock and data pins carry the SPI clock and SPI data-in.

Every transfer begins with a pointer byte. Bits [6:0] of that byte choose a register. Bit 7 is the increment flag, which decides whether the pointer advances after each data byte. All pins pass through two-flop synchronisers into the system clock domain, so the bus can run with no fixed relation to any other clock in the chip. The register contents drive `cfg_o`. I2C reads return register contents at the pointer.

The I2C engine has these states:
- `I_IDLE` and `I_SKIP` wait for a START.
- `I_ADDR` goes to `I_ADDR_ACK` on a match and to `I_SKIP` on a mismatch.
- `I_ADDR_ACK` goes to `I_PTR` for a write or to `I_RDAT` for a read.
- `I_PTR` goes to `I_PTR_ACK`, then to `I_WDAT`.
- `I_WDAT` and `I_WDAT_ACK` alternate.
- `I_RDAT` and `I_RDAT_ACK` alternate, and a master NACK leads to `I_SKIP`.
- START from any state goes to `I_ADDR`. STOP from any state goes to `I_IDLE`.

The SPI engine has these states:
- `S_IDLE` goes to `S_CHIP` when chip select goes low.
- `S_CHIP` goes to `S_PTR` or to `S_SKIP`, depending on the chip byte.
- `S_PTR` goes to `S_DATA`.
- Chip select going high returns the engine to `S_IDLE`.

The top-level mode register goes from `MODE_I2C` to `MODE_SPI` and never back.

Top module: `ctlp_port`

## Requirements
- R1: After reset, all registers read zero, `sda_oe_o` is 0 (bus released), and the port is in I2C mode.
- R2: An I2C address byte matches when bits [7:1] equal 0011000 with bit 1 replaced by the level of `sel_i`. Bit 0 is the R/W bit, with 0 for write. On a match the slave pulls SDA low in the ninth clock (ACK). On a mismatch it never drives SDA and changes no register until the next START.
- R3: In an I2C write, the pointer byte and each data byte are acknowledged, and each data byte is stored in the register selected by the pointer.
- R4: When bit 7 of the pointer byte is 1, the pointer advances by one after each data byte written or read.
- R5: When bit 7 of the pointer byte is 0, the pointer does not move, so successive data bytes write or read the same register.
- R6: An I2C read (R/W=1) returns the register at the current pointer, MSB first. It continues while the master acknowledges and ends when the master NACKs.
- R7: A falling edge on `sel_i` after reset selects SPI mode permanently. From then on, I2C traffic is ignored and SDA is never driven.
- R8: An SPI frame lasts while `sel_i` is low, with bits sampled MSB first on rising SCL edges. It carries a chip byte 0x30 (0011000 with R/W=0), a pointer byte and data bytes. Any other chip byte makes the rest of the frame ignored.
- R9: A pointer value of 8 or more, which is past the last register, makes writes have no effect, and reads there return 0.
- R10: A START during a transfer restarts the address phase. A STOP returns the slave to idle with SDA released.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock, or SPI clock in SPI mode |
| sda_i | input | 1 | I2C data as seen on the bus, or SPI data-in in SPI mode |
| sel_i | input | 1 | Address bit in I2C mode; active-low chip select in SPI mode |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| cfg_o | output | NREG*8 | Register contents, register k at bits [8k+7:8k] |

## Verification
The I2C write path is exercised with the increment flag set, where a three-byte burst must land in three consecutive registers, and with the flag cleared, where the same burst must leave only its last byte in one register. Reads repeat both pointer modes and end with a master NACK, so a slave that drives data too long or stops too early is caught. Address patterns with the wrong select level, and a pointer past the last register, separate acceptance from rejection. SPI frames with a correct and a wrong chip byte, followed by I2C traffic after the mode switch, separate the latching of SPI mode from ordinary select levels.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
    localparam logic [5:0] DEV_ID = 6'b001100;

    typedef enum logic [3:0] {
        I_IDLE, I_ADDR, I_ADDR_ACK, I_PTR, I_PTR_ACK,
        I_WDAT, I_WDAT_ACK, I_RDAT, I_RDAT_ACK, I_SKIP
    } i2c_st_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CHIP, S_PTR, S_DATA, S_SKIP
    } spi_st_t;

    typedef enum logic {MODE_I2C, MODE_SPI} port_mode_t;
endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ctlp_regs.sv
module ctlp_regs #(
    parameter int NREG  = 8,
    parameter int PTR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_addr == PTR_W'(g))
                regs[g] <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++)
            if (rd_addr == PTR_W'(k)) rd_data = regs[k];
    end

    // R9: a write past the last register leaves the bank untouched
    assert_wr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= PTR_W'(NREG)) |=> $stable(regs_flat));
endmodule

// File: rtl/ctlp_i2c.sv
module ctlp_i2c
    import ctlp_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             scl,
    input  logic             sda,
    input  logic             ad0,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    i2c_st_t    st, nxt;
    logic       scl_d, sda_d, ackd, incr, rd_mode;
    logic [2:0] cnt;
    logic [6:0] shreg;
    logic       scl_rise, scl_fall, start_c, stop_c;
    logic [7:0] byte_in;

    assign scl_rise = scl & ~scl_d;
    assign scl_fall = ~scl & scl_d;
    assign start_c  = scl & scl_d & sda_d & ~sda;
    assign stop_c   = scl & scl_d & ~sda_d & sda;
    assign byte_in  = {shreg, sda};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= I_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!en)          nxt = I_IDLE;
        else if (start_c) nxt = I_ADDR;
        else if (stop_c)  nxt = I_IDLE;
        else begin
            unique case (st)
                I_IDLE, I_SKIP: nxt = st;
                I_ADDR:     if (scl_rise && cnt == 3'd7)
                                nxt = (byte_in[7:1] == {DEV_ID, ad0}) ? I_ADDR_ACK : I_SKIP;
                I_ADDR_ACK: if (scl_fall && ackd) nxt = rd_mode ? I_RDAT : I_PTR;
                I_PTR:      if (scl_rise && cnt == 3'd7) nxt = I_PTR_ACK;
                I_PTR_ACK:  if (scl_fall && ackd) nxt = I_WDAT;
                I_WDAT:     if (scl_rise && cnt == 3'd7) nxt = I_WDAT_ACK;
                I_WDAT_ACK: if (scl_fall && ackd) nxt = I_WDAT;
                I_RDAT:     if (scl_fall && cnt == 3'd7) nxt = I_RDAT_ACK;
                I_RDAT_ACK: if (scl_rise && sda) nxt = I_SKIP;
                            else if (scl_fall && ackd) nxt = I_RDAT;
                default:    nxt = I_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b0; sda_d <= 1'b0; ackd <= 1'b0; incr <= 1'b0;
            rd_mode <= 1'b0; cnt <= '0; shreg <= '0; ptr <= '0;
            wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; sda_oe <= 1'b0;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
            wr_en <= 1'b0;
            if (!en || start_c || stop_c) begin
                cnt <= '0; ackd <= 1'b0; sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    I_ADDR, I_PTR, I_WDAT: if (scl_rise) begin
                        shreg <= byte_in[6:0];
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            ackd <= 1'b0;
                            if (st == I_ADDR) rd_mode <= sda;
                            if (st == I_PTR) begin
                                ptr  <= byte_in[PTR_W-1:0];
                                incr <= byte_in[7];
                            end
                            if (st == I_WDAT) begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= byte_in;
                                ptr     <= ptr + {{(PTR_W-1){1'b0}}, incr};
                            end
                        end
                    end
                    I_ADDR_ACK, I_PTR_ACK, I_WDAT_ACK: if (scl_fall) begin
                        if (!ackd) begin
                            ackd <= 1'b1; sda_oe <= 1'b1;
                        end else begin
                            ackd <= 1'b0; sda_oe <= 1'b0;
                            if (st == I_ADDR_ACK && rd_mode) begin
                                shreg <= rd_data[6:0]; sda_oe <= ~rd_data[7]; cnt <= '0;
                            end
                        end
                    end
                    I_RDAT: if (scl_fall) begin
                        if (cnt == 3'd7) begin
                            sda_oe <= 1'b0; cnt <= '0; ackd <= 1'b0;
                            ptr <= ptr + {{(PTR_W-1){1'b0}}, incr};
                        end else begin
                            shreg  <= {shreg[5:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            cnt    <= cnt + 3'd1;
                        end
                    end
                    I_RDAT_ACK: begin
                        if (scl_rise && !sda) ackd <= 1'b1;
                        if (scl_fall && ackd) begin
                            ackd <= 1'b0; shreg <= rd_data[6:0];
                            sda_oe <= ~rd_data[7]; cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: drive changes only follow a low SCL sample
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl));
    // R2: a rejected address keeps the bus released
    assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == I_SKIP && $past(st) == I_SKIP) |-> !sda_oe);
    // R10: STOP returns to idle
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stop_c && !start_c) |=> (st == I_IDLE && !sda_oe));
endmodule

// File: rtl/ctlp_spi.sv
module ctlp_spi
    import ctlp_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cs,
    input  logic             sck,
    input  logic             sdi,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data
);
    spi_st_t          st, nxt;
    logic             sck_d, incr;
    logic [2:0]       cnt;
    logic [6:0]       shreg;
    logic [PTR_W-1:0] ptr;
    logic             sck_rise;
    logic [7:0]       byte_in;

    assign sck_rise = sck & ~sck_d;
    assign byte_in  = {shreg, sdi};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!en || cs) nxt = S_IDLE;
        else begin
            unique case (st)
                S_IDLE: nxt = S_CHIP;
                S_CHIP: if (sck_rise && cnt == 3'd7)
                            nxt = (byte_in == {DEV_ID, 2'b00}) ? S_PTR : S_SKIP;
                S_PTR:  if (sck_rise && cnt == 3'd7) nxt = S_DATA;
                S_DATA, S_SKIP: nxt = st;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0; incr <= 1'b0; cnt <= '0; shreg <= '0; ptr <= '0;
            wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
        end else begin
            sck_d <= sck;
            wr_en <= 1'b0;
            if (!en || cs) begin
                cnt <= '0;
            end else if (sck_rise && (st == S_CHIP || st == S_PTR || st == S_DATA)) begin
                shreg <= byte_in[6:0];
                cnt   <= cnt + 3'd1;
                if (cnt == 3'd7 && st == S_PTR) begin
                    ptr  <= byte_in[PTR_W-1:0];
                    incr <= byte_in[7];
                end
                if (cnt == 3'd7 && st == S_DATA) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= byte_in;
                    ptr     <= ptr + {{(PTR_W-1){1'b0}}, incr};
                end
            end
        end
    end

    // R8: writes only come out of a frame with select low
    assert_wr_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(cs));
endmodule

// File: rtl/ctlp_port.sv
module ctlp_port
    import ctlp_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int PTR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              sel_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] cfg_o
);
    logic [2:0]       sync_q;
    logic             scl_s, sda_s, sel_s, sel_d;
    port_mode_t       mode;
    logic             i_we, s_we, wr_en;
    logic [PTR_W-1:0] i_wa, s_wa, wr_addr, i_ptr;
    logic [7:0]       i_wd, s_wd, wr_data, rd_data;

    ctlp_sync #(.W(3)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({sel_i, sda_i, scl_i}), .q(sync_q)
    );
    assign {sel_s, sda_s, scl_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_d <= 1'b0;
            mode  <= MODE_I2C;
        end else begin
            sel_d <= sel_s;
            if (sel_d && !sel_s) mode <= MODE_SPI;
        end
    end

    ctlp_i2c #(.PTR_W(PTR_W)) i2c_i (
        .clk(clk), .rst_n(rst_n), .en(mode == MODE_I2C), .scl(scl_s), .sda(sda_s),
        .ad0(sel_s), .rd_data(rd_data), .ptr(i_ptr), .wr_en(i_we),
        .wr_addr(i_wa), .wr_data(i_wd), .sda_oe(sda_oe_o)
    );

    ctlp_spi #(.PTR_W(PTR_W)) spi_i (
        .clk(clk), .rst_n(rst_n), .en(mode == MODE_SPI), .cs(sel_s), .sck(scl_s),
        .sdi(sda_s), .wr_en(s_we), .wr_addr(s_wa), .wr_data(s_wd)
    );

    always_comb begin
        wr_en   = i_we | s_we;
        wr_addr = (mode == MODE_SPI) ? s_wa : i_wa;
        wr_data = (mode == MODE_SPI) ? s_wd : i_wd;
    end

    ctlp_regs #(.NREG(NREG), .PTR_W(PTR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(i_ptr), .rd_data(rd_data), .regs_flat(cfg_o)
    );

    // R7: SPI mode is never left
    assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SPI) |=> (mode == MODE_SPI));
    // R7: in SPI mode the data pin is never pulled
    assert_spi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SPI) |=> !sda_oe_o);
    // R8: the two engines never write together
    assert_one_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_we, s_we}));
endmodule

// File: tb/ctlp_port_tb_top.sv
module ctlp_port_tb_top;
    localparam int NREG = 8;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, sel = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] cfg;
    logic bus_sda;

    int  nchk = 0, nbad = 0;
    int  mreg [NREG];
    int  mptr = 0;
    bit  mincr = 1'b0;
    bit  cmp_en = 1'b0;

    always #2 clk = ~clk;
    assign bus_sda = m_sda & ~sda_oe;

    ctlp_port #(.NREG(NREG), .PTR_W(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sel_i(sel),
        .sda_oe_o(sda_oe), .cfg_o(cfg)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R3/R9 reference model compared every clock while the bus is quiet
    always @(negedge clk) if (cmp_en) begin
        for (int i = 0; i < NREG; i++)
            chk(int'(cfg[i*8 +: 8]) == mreg[i], "R3", "register model", int'(cfg[i*8 +: 8]), mreg[i]);
        chk(sda_oe == 1'b0, "R10", "idle release", int'(sda_oe), 0);
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic m_ptr(input logic [7:0] p); mptr = int'(p[6:0]); mincr = p[7]; endtask
    task automatic m_wr(input logic [7:0] d);
        if (mptr < NREG) mreg[mptr] = int'(d);
        if (mincr) mptr = (mptr + 1) % 128;
    endtask
    function automatic int m_rd_peek(); return (mptr < NREG) ? mreg[mptr] : 0; endfunction

    task automatic i_start();
        cmp_en = 1'b0;
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask
    task automatic i_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
        cmp_en = 1'b1;
    endtask
    task automatic bit_out(input logic b);
        m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    endtask
    task automatic bit_in(output logic b);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = bus_sda; wq(); m_scl = 1'b0; wq();
    endtask
    task automatic w_byte(input logic [7:0] b, output bit ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(x);
        ack = !x;
    endtask
    task automatic r_byte(input bit nack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin bit_in(x); b[i] = x; end
        bit_out(nack);
    endtask

    task automatic i_write(input logic [7:0] a, input logic [7:0] p, input logic [7:0] d[$], input string req);
        bit ack;
        i_start();
        w_byte(a, ack); chk(ack, "R2", "address ACK", int'(ack), 1);
        w_byte(p, ack); chk(ack, req, "pointer ACK", int'(ack), 1);
        m_ptr(p);
        foreach (d[k]) begin
            w_byte(d[k], ack); chk(ack, req, "data ACK", int'(ack), 1);
            m_wr(d[k]);
        end
        i_stop();
    endtask

    task automatic i_read(input logic [7:0] a, input int n, input string req);
        bit ack;
        logic [7:0] b;
        w_byte(a, ack); chk(ack, "R2", "read address ACK", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            int e;
            e = m_rd_peek();
            r_byte(k == n - 1, b);
            chk(int'(b) == e, req, "read byte", int'(b), e);
            if (mincr) mptr = (mptr + 1) % 128;
        end
        i_stop();
    endtask

    task automatic i_reject(input logic [7:0] a, input string req);
        bit ack;
        i_start();
        w_byte(a, ack); chk(!ack, req, "no ACK on wrong address", int'(ack), 0);
        w_byte(8'h80, ack); chk(!ack, req, "no ACK after reject", int'(ack), 0);
        w_byte(8'hEE, ack); chk(!ack, req, "no ACK on data after reject", int'(ack), 0);
        i_stop();
    endtask

    task automatic spi_frame(input logic [7:0] d[$]);
        cmp_en = 1'b0;
        m_scl = 1'b0; wq(); sel = 1'b0; wq(); wq();
        foreach (d[k])
            for (int i = 7; i >= 0; i--) begin
                m_sda = d[k][i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0;
            end
        wq(); sel = 1'b1; wq(); m_scl = 1'b1; m_sda = 1'b1; wq(); wq();
        if (d.size() >= 2 && d[0] == 8'h30) begin
            m_ptr(d[1]);
            for (int k = 2; k < d.size(); k++) m_wr(d[k]);
        end
        cmp_en = 1'b1;
    endtask

    initial begin
        logic [7:0] q[$];
        bit ack;
        for (int i = 0; i < NREG; i++) mreg[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cfg == '0, "R1", "registers after reset", int'(cfg[31:0]), 0);
        chk(sda_oe == 1'b0, "R1", "bus released after reset", int'(sda_oe), 0);
        cmp_en = 1'b1;

        // R3 R4: incrementing write burst at register 1
        q = '{8'hA5, 8'h3C, 8'h7E};
        i_write(8'h30, 8'h81, q, "R4");
        // R5: fixed pointer, last byte wins
        q = '{8'h11, 8'h22, 8'h33};
        i_write(8'h30, 8'h05, q, "R5");

        // R6 R10: pointer set then repeated START into a read burst
        i_start();
        w_byte(8'h30, ack); chk(ack, "R2", "address ACK", int'(ack), 1);
        w_byte(8'h81, ack); chk(ack, "R3", "pointer ACK", int'(ack), 1);
        m_ptr(8'h81);
        i_start();
        i_read(8'h31, 3, "R6");
        // R5: fixed-pointer read
        q = '{};
        i_write(8'h30, 8'h05, q, "R5");
        i_start();
        i_read(8'h31, 2, "R5");

        // R2: wrong select level in the address
        i_reject(8'h32, "R2");

        // R2 R9: select high changes the address; past-end pointer
        sel = 1'b1; wq(); wq();
        i_reject(8'h30, "R2");
        q = '{8'h9A, 8'h5B};
        i_write(8'h32, 8'h87, q, "R9");
        i_start();
        i_read(8'h33, 1, "R9");

        // R10: repeated START in the middle of a write
        i_start();
        w_byte(8'h32, ack); chk(ack, "R10", "address ACK", int'(ack), 1);
        w_byte(8'h06, ack); m_ptr(8'h06);
        w_byte(8'h44, ack); chk(ack, "R10", "data ACK", int'(ack), 1); m_wr(8'h44);
        i_start();
        w_byte(8'h32, ack); chk(ack, "R10", "restart address ACK", int'(ack), 1);
        w_byte(8'h00, ack); m_ptr(8'h00);
        w_byte(8'h55, ack); chk(ack, "R10", "restart data ACK", int'(ack), 1); m_wr(8'h55);
        i_stop();

        // R7 R8: falling select enters SPI mode
        q = '{8'h30, 8'h82, 8'hDE, 8'hAD};
        spi_frame(q);
        q = '{8'h30, 8'h04, 8'h01, 8'h02};
        spi_frame(q);
        q = '{8'h32, 8'h00, 8'h77};
        spi_frame(q);
        chk(int'(cfg[7:0]) == 8'h55, "R8", "wrong chip byte ignored", int'(cfg[7:0]), 8'h55);

        // R7: I2C traffic is ignored in SPI mode
        i_reject(8'h32, "R7");
        chk(int'(cfg[7:0]) == 8'h55, "R7", "register 0 kept", int'(cfg[7:0]), 8'h55);

        repeat (10) @(negedge clk);
        summary();
    end
endmodule